// File: doc/BRIEF.md
# Dual-Clock Dual-Port Word Memory with Burst Address Counters

This block is a true dual-port synchronous RAM with two independent ports, left and right. Each port has its own clock and its own reset. Either port can read or write any word in any cycle, and both ports may touch the same word in the same cycle. Every control, address and data input is captured on the rising edge of its port's clock.

Each port owns an address counter. Every access goes through this counter. In a cycle the counter can be cleared to zero, loaded from the address pins, stepped by one, or left as it is. A master can therefore start a burst with one address and then let the port generate the addresses that follow. The counter's new value is also the address of that same cycle's access, so a clear or a load costs no extra cycle.

Each port also has:
- a run-time latency select, which chooses between flow-through and pipelined reads;
- two active-low byte-lane enables;
- a pair of selects of opposite polarity;
- an asynchronous output-enable gate.

The bidirectional data bus is split into a data-in bus, a data-out bus, and a per-lane drive-enable output. The depth is `2**ADDR_W` words. `ADDR_W = 14` gives the 16384 x 16 organisation. The default is smaller so that the default build stays light.

Top module: `dpr_top`

## Requirements
- R1: The memory holds 2**ADDR_W words of DATA_W = 2*LANE_W bits. A word written through either port reads back unchanged through either port until it is written again.
- R2: With `lat2_x` = 0 (flow-through), read data and lane drive enables for an access captured at clock edge k are present throughout the cycle that follows edge k.
- R3: With `lat2_x` = 1 (pipelined), the same read result appears one cycle later, in the cycle that follows edge k+1.
- R4: A write updates only the lanes whose enable is low. `lo_x_n` controls bits 7:0 and `hi_x_n` controls bits 15:8. The other lane of the word keeps its contents.
- R5: A read drives only the enabled lanes. `dq_oe_x[0]` is the lower lane and `dq_oe_x[1]` is the upper lane.
- R6: A port is selected only when `cs_x_n` = 0 and `cs_x` = 1. A deselected cycle writes nothing and drives nothing. After reset, no lane is driven.
- R7: `out_en_x_n` = 1 forces `dq_oe_x` to 0 at once, even in a read cycle. It has no effect on writes.
- R8: `clr_x_n` = 0 sets the counter to 0, and that same cycle's read or write uses address 0. Port reset also leaves the counter at 0.
- R9: `ld_x_n` = 0 with `clr_x_n` = 1 loads `addr_x` into the counter, and the access of that cycle uses `addr_x`.
- R10: `step_x_n` = 0 with `ld_x_n` = 1 and `clr_x_n` = 1 uses the previous address plus one. The address wraps from 2**ADDR_W-1 to 0.
- R11: With `clr_x_n`, `ld_x_n` and `step_x_n` all high, the access reuses the previous address.
- R12: Counter control priority is clear, then load, then step, then hold.
- R13: When one port writes a word and the other port reads it in the same cycle, the reader gets the old contents. Later reads return the new contents.
- R14: When both ports write one word in the same cycle, lanes enabled on both ports take the left port's data. A lane enabled on only one port takes that port's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_l_n | input | 1 | Left port asynchronous reset, active low |
| cs_l_n | input | 1 | Left select, active low |
| cs_l | input | 1 | Left select, active high |
| wr_l_n | input | 1 | Left write when low, read when high |
| hi_l_n | input | 1 | Left upper lane enable, active low |
| lo_l_n | input | 1 | Left lower lane enable, active low |
| out_en_l_n | input | 1 | Left asynchronous output gate, active low |
| lat2_l | input | 1 | Left latency select: 0 flow-through, 1 pipelined |
| ld_l_n | input | 1 | Left counter load from address pins, active low |
| step_l_n | input | 1 | Left counter step, active low |
| clr_l_n | input | 1 | Left counter clear, active low |
| addr_l | input | ADDR_W | Left external address |
| din_l | input | DATA_W | Left write data |
| dout_l | output | DATA_W | Left read data |
| dq_oe_l | output | DATA_W/LANE_W | Left per-lane drive enable |
| clk_r | input | 1 | Right port clock |
| rst_r_n | input | 1 | Right port asynchronous reset, active low |
| cs_r_n | input | 1 | Right select, active low |
| cs_r | input | 1 | Right select, active high |
| wr_r_n | input | 1 | Right write when low, read when high |
| hi_r_n | input | 1 | Right upper lane enable, active low |
| lo_r_n | input | 1 | Right lower lane enable, active low |
| out_en_r_n | input | 1 | Right asynchronous output gate, active low |
| lat2_r | input | 1 | Right latency select: 0 flow-through, 1 pipelined |
| ld_r_n | input | 1 | Right counter load from address pins, active low |
| step_r_n | input | 1 | Right counter step, active low |
| clr_r_n | input | 1 | Right counter clear, active low |
| addr_r | input | ADDR_W | Right external address |
| din_r | input | DATA_W | Right write data |
| dout_r | output | DATA_W | Right read data |
| dq_oe_r | output | DATA_W/LANE_W | Right per-lane drive enable |

## Verification
On every cycle the assertions check the left counter's clear, load, step and hold rules. They also check the output gate, the silence that follows a deselected cycle in both latency modes, and lane gating by the upper enable.

The memory contents are not visible to a property. Lane-masked write merging, old-data return on a cross-port collision, left-port precedence on a double write, and read-back of every word under both latencies are therefore shown only by the bench. The bench compares each port on each cycle with a reference word array.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   typedef enum logic [1:0] {
      CTR_HOLD = 2'd0,
      CTR_STEP = 2'd1,
      CTR_LOAD = 2'd2,
      CTR_ZERO = 2'd3
   } ctr_op_e;

   // clear beats load, load beats step, step beats hold
   function automatic ctr_op_e ctr_decode(input logic clr_n, input logic ld_n,
                                          input logic step_n);
      if (!clr_n)       return CTR_ZERO;
      else if (!ld_n)   return CTR_LOAD;
      else if (!step_n) return CTR_STEP;
      else              return CTR_HOLD;
   endfunction

endpackage

// File: rtl/dpr_addr_ctr.sv
module dpr_addr_ctr
   import dpr_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_n,
   input  logic              ld_n,
   input  logic              step_n,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] addr_q
);

   ctr_op_e           op;
   logic [ADDR_W-1:0] addr_nx;

   always_comb begin
      op = ctr_decode(clr_n, ld_n, step_n);
      unique case (op)
         CTR_ZERO: addr_nx = '0;
         CTR_LOAD: addr_nx = ext_addr;
         CTR_STEP: addr_nx = addr_q + 1'b1;
         default:  addr_nx = addr_q;
      endcase
   end

   // the counter register is also the access address of the cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr_nx;
   end

endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
   parameter int ADDR_W = 11,
   parameter int LANE_W = 8,
   parameter int LANES  = 2,
   localparam int DW    = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              cs,
   input  logic              wr_n,
   input  logic [LANES-1:0]  lane_n,
   input  logic              out_en_n,
   input  logic              lat2,
   input  logic              ld_n,
   input  logic              step_n,
   input  logic              clr_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DW-1:0]     din,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [LANES-1:0]  wr_lanes,
   output logic [DW-1:0]     wr_data,
   input  logic [DW-1:0]     rd_data,
   output logic [DW-1:0]     dout,
   output logic [LANES-1:0]  dq_oe
);

   logic             rd_q, wr_q;
   logic [LANES-1:0] lane_q;
   logic [LANES-1:0] rd_lanes_q2;
   logic [DW-1:0]    rd_data_q2;
   logic [LANES-1:0] rd_lanes;
   logic [LANES-1:0] drive;

   dpr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_n    (clr_n),
      .ld_n     (ld_n),
      .step_n   (step_n),
      .ext_addr (addr_i),
      .addr_q   (acc_addr)
   );

   // capture stage: select, direction, lanes and write data
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q    <= 1'b0;
         wr_q    <= 1'b0;
         lane_q  <= '0;
         wr_data <= '0;
      end else begin
         rd_q    <= !cs_n && cs && wr_n;
         wr_q    <= !cs_n && cs && !wr_n;
         lane_q  <= ~lane_n;
         wr_data <= din;
      end
   end

   assign rd_lanes = {LANES{rd_q}} & lane_q;
   assign wr_lanes = {LANES{wr_q}} & lane_q;

   // extra output stage used in pipelined mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_lanes_q2 <= '0;
         rd_data_q2  <= '0;
      end else begin
         rd_lanes_q2 <= rd_lanes;
         rd_data_q2  <= rd_data;
      end
   end

   assign drive = lat2 ? rd_lanes_q2 : rd_lanes;
   assign dout  = lat2 ? rd_data_q2 : rd_data;
   assign dq_oe = drive & {LANES{!out_en_n}};

endmodule

// File: rtl/dpr_xor_lane.sv
module dpr_xor_lane #(
   parameter int ADDR_W = 11,
   parameter int LANE_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk_a,
   input  logic              we_a,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [LANE_W-1:0] wdata_a,
   output logic [LANE_W-1:0] rdata_a,
   input  logic              clk_b,
   input  logic              we_b,
   input  logic [ADDR_W-1:0] addr_b,
   input  logic [LANE_W-1:0] wdata_b,
   output logic [LANE_W-1:0] rdata_b
);

   // each bank has exactly one writer; a word's value is bank_a ^ bank_b
   logic [LANE_W-1:0] bank_a [DEPTH];
   logic [LANE_W-1:0] bank_b [DEPTH];
   logic              b_yields;

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         bank_a[i] = '0;
         bank_b[i] = '0;
      end
   end

   // port b gives way to a same-word, same-lane write from port a
   assign b_yields = we_a && (addr_a == addr_b);

   always_ff @(posedge clk_a) begin
      if (we_a) bank_a[addr_a] <= wdata_a ^ bank_b[addr_a];
   end

   always_ff @(posedge clk_b) begin
      if (we_b && !b_yields) bank_b[addr_b] <= wdata_b ^ bank_a[addr_b];
   end

   assign rdata_a = bank_a[addr_a] ^ bank_b[addr_a];
   assign rdata_b = bank_a[addr_b] ^ bank_b[addr_b];

endmodule

// File: rtl/dpr_top.sv
module dpr_top #(
   parameter int ADDR_W = 11,
   parameter int LANE_W = 8,
   parameter int DATA_W = 16,
   localparam int LANES = DATA_W / LANE_W
) (
   input  logic              clk_l,
   input  logic              rst_l_n,
   input  logic              cs_l_n,
   input  logic              cs_l,
   input  logic              wr_l_n,
   input  logic              hi_l_n,
   input  logic              lo_l_n,
   input  logic              out_en_l_n,
   input  logic              lat2_l,
   input  logic              ld_l_n,
   input  logic              step_l_n,
   input  logic              clr_l_n,
   input  logic [ADDR_W-1:0] addr_l,
   input  logic [DATA_W-1:0] din_l,
   output logic [DATA_W-1:0] dout_l,
   output logic [LANES-1:0]  dq_oe_l,
   input  logic              clk_r,
   input  logic              rst_r_n,
   input  logic              cs_r_n,
   input  logic              cs_r,
   input  logic              wr_r_n,
   input  logic              hi_r_n,
   input  logic              lo_r_n,
   input  logic              out_en_r_n,
   input  logic              lat2_r,
   input  logic              ld_r_n,
   input  logic              step_r_n,
   input  logic              clr_r_n,
   input  logic [ADDR_W-1:0] addr_r,
   input  logic [DATA_W-1:0] din_r,
   output logic [DATA_W-1:0] dout_r,
   output logic [LANES-1:0]  dq_oe_r
);

   if (DATA_W != 2 * LANE_W) begin : g_bad_width
      $error("dpr_top: two lane enables need DATA_W == 2*LANE_W");
   end
   if (ADDR_W < 2) begin : g_bad_depth
      $error("dpr_top: ADDR_W must be at least 2");
   end

   logic [ADDR_W-1:0] acc_l, acc_r;
   logic [LANES-1:0]  wl_l, wl_r;
   logic [DATA_W-1:0] wd_l, wd_r, rd_l, rd_r;

   dpr_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_left (
      .clk(clk_l), .rst_n(rst_l_n), .cs_n(cs_l_n), .cs(cs_l), .wr_n(wr_l_n),
      .lane_n({hi_l_n, lo_l_n}), .out_en_n(out_en_l_n), .lat2(lat2_l),
      .ld_n(ld_l_n), .step_n(step_l_n), .clr_n(clr_l_n), .addr_i(addr_l),
      .din(din_l), .acc_addr(acc_l), .wr_lanes(wl_l), .wr_data(wd_l),
      .rd_data(rd_l), .dout(dout_l), .dq_oe(dq_oe_l)
   );

   dpr_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_right (
      .clk(clk_r), .rst_n(rst_r_n), .cs_n(cs_r_n), .cs(cs_r), .wr_n(wr_r_n),
      .lane_n({hi_r_n, lo_r_n}), .out_en_n(out_en_r_n), .lat2(lat2_r),
      .ld_n(ld_r_n), .step_n(step_r_n), .clr_n(clr_r_n), .addr_i(addr_r),
      .din(din_r), .acc_addr(acc_r), .wr_lanes(wl_r), .wr_data(wd_r),
      .rd_data(rd_r), .dout(dout_r), .dq_oe(dq_oe_r)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      dpr_xor_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
         .clk_a   (clk_l),
         .we_a    (wl_l[g]),
         .addr_a  (acc_l),
         .wdata_a (wd_l[g*LANE_W +: LANE_W]),
         .rdata_a (rd_l[g*LANE_W +: LANE_W]),
         .clk_b   (clk_r),
         .we_b    (wl_r[g]),
         .addr_b  (acc_r),
         .wdata_b (wd_r[g*LANE_W +: LANE_W]),
         .rdata_b (rd_r[g*LANE_W +: LANE_W])
      );
   end

endmodule

// File: rtl/dpr_chk.sv
module dpr_chk #(
   parameter int ADDR_W = 11,
   parameter int LANES  = 2
) (
   input logic              clk_l,
   input logic              rst_l_n,
   input logic              cs_l_n,
   input logic              cs_l,
   input logic              hi_l_n,
   input logic              out_en_l_n,
   input logic              lat2_l,
   input logic              ld_l_n,
   input logic              step_l_n,
   input logic              clr_l_n,
   input logic [ADDR_W-1:0] addr_l,
   input logic [LANES-1:0]  dq_oe_l,
   input logic [ADDR_W-1:0] ctr_l,
   input logic              clk_r,
   input logic              rst_r_n,
   input logic              cs_r_n,
   input logic              cs_r,
   input logic              lat2_r,
   input logic [LANES-1:0]  dq_oe_r
);

   logic [1:0] live_l, live_r;

   always_ff @(posedge clk_l or negedge rst_l_n) begin
      if (!rst_l_n)          live_l <= 2'd0;
      else if (live_l != 2'd3) live_l <= live_l + 2'd1;
   end

   always_ff @(posedge clk_r or negedge rst_r_n) begin
      if (!rst_r_n)          live_r <= 2'd0;
      else if (live_r != 2'd3) live_r <= live_r + 2'd1;
   end

   AST_CTR_ZERO: assert property (@(posedge clk_l) disable iff (!rst_l_n)
      (live_l != 0) && $past(!clr_l_n) |-> ctr_l == '0); // R8

   AST_CTR_LOAD: assert property (@(posedge clk_l) disable iff (!rst_l_n)
      (live_l != 0) && $past(clr_l_n && !ld_l_n) |-> ctr_l == $past(addr_l)); // R9

   AST_CTR_STEP: assert property (@(posedge clk_l) disable iff (!rst_l_n)
      (live_l != 0) && $past(clr_l_n && ld_l_n && !step_l_n)
      |-> ctr_l == ADDR_W'($past(ctr_l) + 1'b1)); // R10

   AST_CTR_HOLD: assert property (@(posedge clk_l) disable iff (!rst_l_n)
      (live_l != 0) && $past(clr_l_n && ld_l_n && step_l_n)
      |-> $stable(ctr_l)); // R11

   AST_OE_GATE_L: assert property (@(posedge clk_l) disable iff (!rst_l_n)
      out_en_l_n |-> dq_oe_l == '0); // R7

   AST_DESEL_FT_L: assert property (@(posedge clk_l) disable iff (!rst_l_n)
      (live_l != 0) && !lat2_l && $past(cs_l_n || !cs_l) |-> dq_oe_l == '0); // R6

   AST_DESEL_PIPE_R: assert property (@(posedge clk_r) disable iff (!rst_r_n)
      (live_r > 1) && lat2_r && $past(cs_r_n || !cs_r, 2) |-> dq_oe_r == '0); // R6

   AST_DESEL_FT_R: assert property (@(posedge clk_r) disable iff (!rst_r_n)
      (live_r != 0) && !lat2_r && $past(cs_r_n || !cs_r) |-> dq_oe_r == '0); // R6

   AST_UPPER_LANE_FT: assert property (@(posedge clk_l) disable iff (!rst_l_n)
      (live_l != 0) && !lat2_l && $past(hi_l_n) |-> !dq_oe_l[1]); // R5

endmodule

bind dpr_top dpr_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
   .clk_l(clk_l), .rst_l_n(rst_l_n), .cs_l_n(cs_l_n), .cs_l(cs_l),
   .hi_l_n(hi_l_n), .out_en_l_n(out_en_l_n), .lat2_l(lat2_l), .ld_l_n(ld_l_n),
   .step_l_n(step_l_n), .clr_l_n(clr_l_n), .addr_l(addr_l), .dq_oe_l(dq_oe_l),
   .ctr_l(u_left.acc_addr), .clk_r(clk_r), .rst_r_n(rst_r_n), .cs_r_n(cs_r_n),
   .cs_r(cs_r), .lat2_r(lat2_r), .dq_oe_r(dq_oe_r)
);

// File: tb/tb_dpr_top.sv
module tb_dpr_top;

   localparam int AW    = 6;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n;
   always #5 clk = ~clk;

   logic          cs_n [2], cs [2], wr_n [2], hi_n [2], lo_n [2], oen [2];
   logic          lat2 [2], ld_n [2], step_n [2], clr_n [2];
   logic [AW-1:0] addr [2];
   logic [15:0]   din [2];
   logic [15:0]   dout_lw, dout_rw;
   logic [1:0]    oe_lw, oe_rw;

   dpr_top #(.ADDR_W(AW), .LANE_W(8), .DATA_W(16)) dut (
      .clk_l(clk), .rst_l_n(rst_n), .cs_l_n(cs_n[0]), .cs_l(cs[0]), .wr_l_n(wr_n[0]),
      .hi_l_n(hi_n[0]), .lo_l_n(lo_n[0]), .out_en_l_n(oen[0]), .lat2_l(lat2[0]),
      .ld_l_n(ld_n[0]), .step_l_n(step_n[0]), .clr_l_n(clr_n[0]), .addr_l(addr[0]),
      .din_l(din[0]), .dout_l(dout_lw), .dq_oe_l(oe_lw),
      .clk_r(clk), .rst_r_n(rst_n), .cs_r_n(cs_n[1]), .cs_r(cs[1]), .wr_r_n(wr_n[1]),
      .hi_r_n(hi_n[1]), .lo_r_n(lo_n[1]), .out_en_r_n(oen[1]), .lat2_r(lat2[1]),
      .ld_r_n(ld_n[1]), .step_r_n(step_n[1]), .clr_r_n(clr_n[1]), .addr_r(addr[1]),
      .din_r(din[1]), .dout_r(dout_rw), .dq_oe_r(oe_rw)
   );

   int          vectors = 0, errors = 0;
   bit          done = 0;
   string       tag = "R6";
   logic [15:0] mem [DEPTH];
   int          cnt [2];
   logic [1:0]  e1_l [2], e2_l [2];
   logic [15:0] e1_d [2], e2_d [2];

   function automatic logic [15:0] pat(int a);
      return 16'(a * 16'h0321) ^ 16'hA5C3;
   endfunction

   // one port-cycle: selected?, write?, lane enables {hi,lo} active low, address, data, load, step, clear
   task automatic drv(int p, bit sel, bit wr, logic [1:0] ben, int a, logic [15:0] d,
                      bit ld, bit st, bit cl);
      cs_n[p] = !sel; cs[p] = 1'b1; wr_n[p] = !wr;
      {hi_n[p], lo_n[p]} = ben;
      addr[p] = AW'(a); din[p] = d;
      ld_n[p] = !ld; step_n[p] = !st; clr_n[p] = !cl;
   endtask

   task automatic idle(int p);
      drv(p, 0, 0, 2'b11, 0, 16'h0, 0, 0, 0);
   endtask

   task automatic check_port(int p);
      logic [1:0]  el, ol;
      logic [15:0] ed, od;
      bit          bad;
      el = lat2[p] ? e2_l[p] : e1_l[p];
      ed = lat2[p] ? e2_d[p] : e1_d[p];
      if (oen[p]) el = 2'b00;
      ol = (p == 0) ? oe_lw : oe_rw;
      od = (p == 0) ? dout_lw : dout_rw;
      bad = (ol !== el);
      for (int i = 0; i < 2; i++)
         if (el[i] && od[i*8 +: 8] !== ed[i*8 +: 8]) bad = 1;
      vectors++;
      if (bad) begin
         errors++;
         $display("FAIL %s port%0d: dq_oe=%b dout=%h, expected dq_oe=%b dout=%h",
                  tag, p, ol, od, el, ed);
      end
   endtask

   // model the cycle from the applied inputs, clock it, and compare at the next falling edge
   task automatic cycle();
      logic [1:0]  nl [2], wl [2];
      logic [15:0] nd [2];
      int          wa [2];
      for (int p = 0; p < 2; p++) begin
         bit sel;
         int a;
         sel = !cs_n[p] && cs[p];
         if (!clr_n[p])       a = 0;
         else if (!ld_n[p])   a = int'(addr[p]);
         else if (!step_n[p]) a = (cnt[p] + 1) % DEPTH;
         else                 a = cnt[p];
         cnt[p] = a;
         nl[p] = (sel && wr_n[p])  ? ~{hi_n[p], lo_n[p]} : 2'b00;
         wl[p] = (sel && !wr_n[p]) ? ~{hi_n[p], lo_n[p]} : 2'b00;
         nd[p] = mem[a];
         wa[p] = a;
      end
      for (int p = 1; p >= 0; p--)
         for (int i = 0; i < 2; i++)
            if (wl[p][i]) mem[wa[p]][i*8 +: 8] = din[p][i*8 +: 8];
      @(posedge clk);
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
         e2_l[p] = e1_l[p]; e2_d[p] = e1_d[p];
         e1_l[p] = nl[p];   e1_d[p] = nd[p];
         check_port(p);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = 16'h0;
      for (int p = 0; p < 2; p++) begin
         idle(p); oen[p] = 0; lat2[p] = 0; cnt[p] = 0;
         e1_l[p] = 0; e2_l[p] = 0; e1_d[p] = 0; e2_d[p] = 0;
      end
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;

      // R6: nothing driven after reset
      tag = "R6"; cycle(); cycle();

      // R1 R9 R10: left burst fills every word
      tag = "R1";
      drv(0, 1, 1, 2'b00, 0, pat(0), 1, 0, 0); cycle();
      for (int a = 1; a < DEPTH; a++) begin
         drv(0, 1, 1, 2'b00, 0, pat(a), 0, 1, 0); cycle();
      end
      idle(0);

      // R2: right flow-through burst read
      tag = "R2";
      drv(1, 1, 0, 2'b00, 0, 0, 1, 0, 0); cycle();
      for (int a = 1; a < DEPTH; a++) begin
         drv(1, 1, 0, 2'b00, 0, 0, 0, 1, 0); cycle();
      end
      idle(1); cycle();

      // R3: left pipelined burst read
      tag = "R3"; lat2[0] = 1;
      drv(0, 1, 0, 2'b00, 0, 0, 1, 0, 0); cycle();
      for (int a = 1; a < DEPTH; a++) begin
         drv(0, 1, 0, 2'b00, 0, 0, 0, 1, 0); cycle();
      end
      idle(0); cycle(); cycle();

      // R10: wrap from the last word to word 0
      tag = "R10";
      drv(0, 1, 0, 2'b00, DEPTH - 1, 0, 1, 0, 0); cycle();
      drv(0, 1, 0, 2'b00, 5, 0, 0, 1, 0); cycle();
      // R11: hold repeats the same word
      tag = "R11";
      drv(0, 1, 0, 2'b00, 9, 0, 0, 0, 0); cycle(); cycle();
      idle(0); cycle(); cycle();
      lat2[0] = 0;

      // R8: clear gives address 0 with no lost cycle; R12 clear beats load and step
      tag = "R8";
      drv(1, 1, 0, 2'b00, 33, 0, 1, 1, 1); cycle();
      drv(1, 1, 1, 2'b00, 40, 16'hBEEF, 0, 0, 1); cycle();
      drv(1, 1, 0, 2'b00, 0, 0, 0, 0, 0); cycle();
      // R12: load beats step
      tag = "R12";
      drv(1, 1, 0, 2'b00, 21, 0, 1, 1, 0); cycle();
      // R9: plain load
      tag = "R9";
      drv(1, 1, 0, 2'b00, 17, 0, 1, 0, 0); cycle();
      idle(1); cycle();

      // R4: lane-masked writes then full reads
      tag = "R4";
      drv(0, 1, 1, 2'b10, 3, 16'h1122, 1, 0, 0); cycle();
      drv(0, 1, 1, 2'b01, 4, 16'h3344, 1, 0, 0); cycle();
      drv(0, 1, 0, 2'b00, 3, 0, 1, 0, 0); cycle();
      drv(0, 1, 0, 2'b00, 4, 0, 1, 0, 0); cycle();
      // R5: single-lane reads
      tag = "R5";
      drv(0, 1, 0, 2'b10, 4, 0, 1, 0, 0); cycle();
      drv(0, 1, 0, 2'b01, 3, 0, 1, 0, 0); cycle();
      idle(0); cycle();

      // R6: deselected writes by either select leave words unchanged
      tag = "R6";
      drv(0, 0, 1, 2'b00, 8, 16'hDEAD, 1, 0, 0); cycle();
      drv(0, 1, 1, 2'b00, 8, 16'hDEAD, 1, 0, 0); cs[0] = 0; cycle();
      drv(0, 1, 0, 2'b00, 8, 0, 1, 0, 0); cs[0] = 0; cycle();
      drv(0, 1, 0, 2'b00, 8, 0, 1, 0, 0); cycle();

      // R7: output gate blocks drive but not writes
      tag = "R7";
      oen[0] = 1;
      drv(0, 1, 0, 2'b00, 8, 0, 1, 0, 0); cycle();
      drv(0, 1, 1, 2'b00, 12, 16'h7E57, 1, 0, 0); cycle();
      oen[0] = 0;
      drv(0, 1, 0, 2'b00, 12, 0, 1, 0, 0); cycle();
      idle(0); cycle();

      // R13: write and read of one word in one cycle, then read again
      tag = "R13";
      drv(0, 1, 1, 2'b00, 7, 16'hC0DE, 1, 0, 0);
      drv(1, 1, 0, 2'b00, 7, 0, 1, 0, 0); cycle();
      idle(0);
      drv(1, 1, 0, 2'b00, 7, 0, 1, 0, 0); cycle();
      drv(1, 1, 1, 2'b00, 14, 16'h0BAD, 1, 0, 0);
      drv(0, 1, 0, 2'b00, 14, 0, 1, 0, 0); cycle();
      idle(1); cycle();

      // R14: both ports write one word; full overlap then partial lanes
      tag = "R14";
      drv(0, 1, 1, 2'b00, 11, 16'hAAAA, 1, 0, 0);
      drv(1, 1, 1, 2'b00, 11, 16'h5555, 1, 0, 0); cycle();
      drv(0, 1, 1, 2'b10, 11, 16'h1111, 1, 0, 0);
      drv(1, 1, 1, 2'b01, 11, 16'h2222, 1, 0, 0); cycle();
      drv(0, 1, 0, 2'b00, 11, 0, 1, 0, 0); idle(1); cycle();
      idle(0); cycle();

      // R1: mixed random traffic on both ports in both latency modes
      tag = "R1";
      for (int n = 0; n < 4000; n++) begin
         if (n % 250 == 0) begin
            lat2[0] = 1'($urandom); lat2[1] = 1'($urandom);
         end
         for (int p = 0; p < 2; p++) begin
            cs_n[p]   = ($urandom % 5) == 0;
            cs[p]     = ($urandom % 7) != 0;
            wr_n[p]   = 1'($urandom);
            hi_n[p]   = 1'($urandom);
            lo_n[p]   = 1'($urandom);
            oen[p]    = ($urandom % 6) == 0;
            ld_n[p]   = ($urandom % 4) != 0;
            step_n[p] = 1'($urandom);
            clr_n[p]  = ($urandom % 13) != 0;
            addr[p]   = AW'($urandom);
            din[p]    = 16'($urandom);
         end
         cycle();
      end
      idle(0); idle(1); oen[0] = 0; oen[1] = 0;
      cycle(); cycle();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule